// File: doc/BRIEF.md
# Grouped Entropy Sample Word Assembler

This block gathers raw bits from a bank of 128 free-running entropy sources and packs them into 64-bit words for a downstream FIFO. The sources are split into 16 groups of eight neighbours, and a 4-bit group index picks the group to use. On each sampling cycle the eight bits of the chosen group are captured side by side as one byte-wide slot. Eight slots make one word, so a word holds eight consecutive samples of each of the eight sources. The word is a time-by-source matrix, not a serial shift of a single stream.

Sampling runs only while three controls are all high: the block enable, the source enable and the raw-output request. The word is offered on a valid/ready handshake. A finished word waits in the output register until the consumer takes it, and no new samples are taken while it waits, so every word holds consecutive, uninterrupted samples. Conditioning, hashing and debiasing belong to later stages.

Top module: `entropy_word_packer`

## Requirements
- R1: A synchronous reset deasserts the output valid and discards any partially assembled word. The first word after reset contains only samples taken after reset.
- R2: In the k-th sampling cycle of a word (k = 0..7), the eight bits of the selected group are written to word bits [8k+7:8k]. Bit 8k+j holds source 8g+j, where g is the group index.
- R3: A group index g in 0..15 selects sources 8g through 8g+7. All 16 values are usable.
- R4: While sampling runs and the consumer keeps ready high, a word is offered every 8 cycles. Valid is high for one cycle per word, and every finished word reaches the output exactly once.
- R5: No word is produced unless the block enable, the source enable and the raw-output request are all high. If any of them drops in the middle of a word, the partial word is discarded and assembly restarts from slot 0.
- R6: If the group index differs, in the middle of a word, from the one latched at slot 0, the partial word is dropped. The cycle in which the change is seen becomes slot 0 of a new word for the new group, and that word completes 8 sampling cycles later.
- R7: While valid is high and ready is low, valid stays high, the data stays unchanged and no sampling takes place. Slot 0 of the next word is sampled in the cycle in which the held word is accepted.
- R8: The bits of the 120 unselected sources have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| blk_en_i | input | 1 | Block enable |
| src_en_i | input | 1 | Entropy source enable |
| raw_req_i | input | 1 | Request for raw, unconditioned output |
| grp_sel_i | input | 4 | Index of the eight-source group to sample |
| src_bits_i | input | 128 | One current sample bit per entropy source |
| word_data_o | output | 64 | Assembled word |
| word_valid_o | output | 1 | Word available |
| word_ready_i | input | 1 | Consumer accepts the word |

## Verification
A slot counter that is off by one shows up at once as a byte in the wrong lane, or as a word offered one cycle early or late, so the first word after the fault already differs. A group register that does not latch correctly only shows when the index changes in the middle of a word: a word of mixed groups appears 8 sampling cycles after the change. A fault in the output stage shows under backpressure: data that moves while held, or a word that is lost or sent twice, is caught at the next acceptance. A gating fault shows as a word that appears while one of the three controls is low.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

   // Two ways to build the group selector.
   typedef enum logic [0:0] {
      MUX_INDEXED = 1'b0,   // variable part-select
      MUX_ANDOR   = 1'b1    // decoded AND-OR reduction
   } mux_style_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ewp_group_mux.sv
module ewp_group_mux #(
   parameter int unsigned         N_SRC     = 128,
   parameter int unsigned         GRP_W     = 8,
   parameter int unsigned         SEL_W     = 4,
   parameter ewp_pkg::mux_style_e MUX_STYLE = ewp_pkg::MUX_INDEXED,
   localparam int unsigned        N_GRP     = N_SRC / GRP_W
) (
   input  logic [N_SRC-1:0] src_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [GRP_W-1:0] slot_o
);

   generate
      if (MUX_STYLE == ewp_pkg::MUX_INDEXED) begin : g_indexed
         assign slot_o = src_i[int'(sel_i)*GRP_W +: GRP_W];
      end else begin : g_andor
         always_comb begin
            slot_o = '0;
            for (int g = 0; g < N_GRP; g++) begin
               if (sel_i == SEL_W'(g)) begin
                  slot_o = slot_o | src_i[g*GRP_W +: GRP_W];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ewp_slot_ctrl.sv
module ewp_slot_ctrl #(
   parameter int unsigned SAMPLES = 8,
   parameter int unsigned SEL_W   = 4,
   localparam int unsigned CNT_W  = ewp_pkg::width_of(SAMPLES)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,     // all three controls high
   input  logic             free_i,    // output stage can take a word
   input  logic [SEL_W-1:0] sel_i,
   output logic             adv_o,     // a slot is sampled this cycle
   output logic [CNT_W-1:0] idx_o,     // slot written this cycle
   output logic             done_o     // last slot written this cycle
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] grp_q;
   logic             start;

   assign adv_o  = run_i && free_i;
   assign start  = adv_o && ((cnt_q == '0) || (sel_i != grp_q));
   assign idx_o  = start ? '0 : cnt_q;
   assign done_o = adv_o && !start && (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         grp_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(1);
         grp_q <= sel_i;
      end else if (done_o) begin
         cnt_q <= '0;
      end else if (adv_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ewp_word_buf.sv
module ewp_word_buf #(
   parameter int unsigned GRP_W   = 8,
   parameter int unsigned SAMPLES = 8,
   localparam int unsigned CNT_W  = ewp_pkg::width_of(SAMPLES),
   localparam int unsigned PART_W = (SAMPLES - 1) * GRP_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [CNT_W-1:0]  wr_idx_i,
   input  logic [GRP_W-1:0]  slot_i,
   output logic [PART_W-1:0] part_o
);

   // One register per slot except the last, which goes straight to the output.
   generate
      for (genvar k = 0; k < SAMPLES - 1; k++) begin : g_slot
         logic [GRP_W-1:0] slot_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == CNT_W'(k))) begin
               slot_q <= slot_i;
            end
         end
         assign part_o[k*GRP_W +: GRP_W] = slot_q;
      end
   endgenerate

endmodule

// File: rtl/ewp_out_stage.sv
module ewp_out_stage #(
   parameter int unsigned WORD_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              ready_i,
   output logic              free_o,
   output logic              valid_o,
   output logic [WORD_W-1:0] data_o
);

   logic              valid_q;
   logic [WORD_W-1:0] data_q;

   assign free_o  = !valid_q || ready_i;
   assign valid_o = valid_q;
   assign data_o  = data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         data_q  <= word_i;
      end else if (ready_i) begin
         valid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/entropy_word_packer.sv
module entropy_word_packer #(
   parameter int unsigned         N_SRC     = 128,
   parameter int unsigned         GRP_W     = 8,
   parameter int unsigned         SAMPLES   = 8,
   parameter ewp_pkg::mux_style_e MUX_STYLE = ewp_pkg::MUX_INDEXED,
   localparam int unsigned        N_GRP     = N_SRC / GRP_W,
   localparam int unsigned        SEL_W     = ewp_pkg::width_of(N_GRP),
   localparam int unsigned        CNT_W     = ewp_pkg::width_of(SAMPLES),
   localparam int unsigned        WORD_W    = GRP_W * SAMPLES,
   localparam int unsigned        PART_W    = (SAMPLES - 1) * GRP_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              blk_en_i,
   input  logic              src_en_i,
   input  logic              raw_req_i,
   input  logic [SEL_W-1:0]  grp_sel_i,
   input  logic [N_SRC-1:0]  src_bits_i,
   output logic [WORD_W-1:0] word_data_o,
   output logic              word_valid_o,
   input  logic              word_ready_i
);

   generate
      if (N_SRC % GRP_W != 0) begin : g_bad_split
         $error("N_SRC must be a multiple of GRP_W");
      end
      if ((1 << SEL_W) != N_GRP) begin : g_bad_groups
         $error("group count must be a power of two");
      end
      if (SAMPLES < 2) begin : g_bad_samples
         $error("SAMPLES must be at least 2");
      end
   endgenerate

   logic              run;
   logic              adv;
   logic              done;
   logic              free;
   logic [CNT_W-1:0]  idx;
   logic [GRP_W-1:0]  slot;
   logic [PART_W-1:0] part;

   assign run = blk_en_i && src_en_i && raw_req_i;

   ewp_group_mux #(
      .N_SRC     (N_SRC),
      .GRP_W     (GRP_W),
      .SEL_W     (SEL_W),
      .MUX_STYLE (MUX_STYLE)
   ) mux_i (
      .src_i  (src_bits_i),
      .sel_i  (grp_sel_i),
      .slot_o (slot)
   );

   ewp_slot_ctrl #(
      .SAMPLES (SAMPLES),
      .SEL_W   (SEL_W)
   ) ctrl_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  (run),
      .free_i (free),
      .sel_i  (grp_sel_i),
      .adv_o  (adv),
      .idx_o  (idx),
      .done_o (done)
   );

   ewp_word_buf #(
      .GRP_W   (GRP_W),
      .SAMPLES (SAMPLES)
   ) buf_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_en_i  (adv),
      .wr_idx_i (idx),
      .slot_i   (slot),
      .part_o   (part)
   );

   ewp_out_stage #(
      .WORD_W (WORD_W)
   ) out_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (done),
      .word_i  ({slot, part}),
      .ready_i (word_ready_i),
      .free_o  (free),
      .valid_o (word_valid_o),
      .data_o  (word_data_o)
   );

endmodule

// File: rtl/ewp_checker.sv
module ewp_checker #(
   parameter int unsigned WORD_W  = 64,
   parameter int unsigned SAMPLES = 8,
   localparam int unsigned GAP_W  = ewp_pkg::width_of(SAMPLES) + 1
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              blk_en_i,
   input logic              src_en_i,
   input logic              raw_req_i,
   input logic              word_valid_o,
   input logic              word_ready_i,
   input logic [WORD_W-1:0] word_data_o
);

   logic             prev_v;
   logic [GAP_W-1:0] gap_q;
   logic             rise;

   assign rise = word_valid_o && !prev_v;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_v <= 1'b0;
         gap_q  <= '0;
      end else begin
         prev_v <= word_valid_o;
         if (rise) begin
            gap_q <= '0;
         end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> !word_valid_o);

   // R7
   hold_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_data_o)));

   // R5
   gated_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(blk_en_i && src_en_i && raw_req_i) |=> !$rose(word_valid_o));

   // R4
   word_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rise |-> (gap_q >= GAP_W'(SAMPLES - 1)));

endmodule

bind entropy_word_packer ewp_checker #(
   .WORD_W  (WORD_W),
   .SAMPLES (SAMPLES)
) chk_i (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .blk_en_i     (blk_en_i),
   .src_en_i     (src_en_i),
   .raw_req_i    (raw_req_i),
   .word_valid_o (word_valid_o),
   .word_ready_i (word_ready_i),
   .word_data_o  (word_data_o)
);

// File: tb/entropy_word_packer_tb_top.sv
module entropy_word_packer_tb_top;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         blk_en = 1'b0;
   logic         src_en = 1'b0;
   logic         raw_req = 1'b0;
   logic [3:0]   grp_sel = '0;
   logic [127:0] src_bits = '0;
   logic [63:0]  word_data;
   logic         word_valid;
   logic         word_ready = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   entropy_word_packer dut_i (
      .clk_i        (clk),
      .rst_i        (rst),
      .blk_en_i     (blk_en),
      .src_en_i     (src_en),
      .raw_req_i    (raw_req),
      .grp_sel_i    (grp_sel),
      .src_bits_i   (src_bits),
      .word_data_o  (word_data),
      .word_valid_o (word_valid),
      .word_ready_i (word_ready)
   );

   typedef struct {
      logic [63:0] w;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          rise_log[$];
   int          checks = 0;
   int          errors = 0;
   int          cyc_n = 0;
   bit          done = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   // reference state, built from the requirements
   int          m_k = 0;
   int          m_grp = 0;
   bit          m_valid = 0;
   logic [63:0] m_word = '0;

   always @(posedge clk) cyc_n++;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rng_step(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   // Driver: applies one cycle of stimulus and updates the expected model.
   task automatic cyc(input bit r, input bit [2:0] gate, input int sel,
                      input bit rdy, input string tag);
      logic [127:0] bits;
      bit run, adv, fin;
      rng = rng_step(rng);
      bits[63:0] = rng;
      rng = rng_step(rng);
      bits[127:64] = rng;
      @(negedge clk);
      #2;
      rst        = r;
      blk_en     = gate[2];
      src_en     = gate[1];
      raw_req    = gate[0];
      grp_sel    = 4'(sel);
      src_bits   = bits;
      word_ready = rdy;
      run = (gate == 3'b111);
      fin = 0;
      if (r) begin
         m_k = 0;
         m_valid = 0;
         sb_q.delete();
      end else begin
         adv = run && (!m_valid || rdy);
         if (!run) begin
            m_k = 0;
         end else if (adv) begin
            if (m_k == 0 || sel != m_grp) begin
               m_grp = sel;
               m_k = 0;
            end
            // only the selected slice is used (R8)
            m_word[m_k*8 +: 8] = bits[sel*8 +: 8];
            if (m_k == 7) begin
               fin = 1;
               m_k = 0;
            end else begin
               m_k++;
            end
         end
         if (fin) begin
            sb_q.push_back('{w: m_word, tag: tag});
            m_valid = 1;
         end else if (rdy) begin
            m_valid = 0;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 3'b000, 0, 1, "idle");
   endtask

   task automatic run_n(input int n, input int sel, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 3'b111, sel, 1, tag);
   endtask

   // Monitor: compares offered words against the scoreboard.
   bit prev_v = 0;
   always @(negedge clk) begin
      #5;
      if (rst) begin
         prev_v = 0;
      end else begin
         if (word_valid && !prev_v) rise_log.push_back(cyc_n);
         if (word_valid) begin
            if (sb_q.size() == 0) begin
               check(0, "R5 unexpected word", word_data, '0);
            end else begin
               check(word_data == sb_q[0].w,
                     word_ready ? sb_q[0].tag : "R7 held word",
                     word_data, sb_q[0].w);
               if (word_ready) void'(sb_q.pop_front());
            end
         end
         prev_v = word_valid;
      end
   end

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(0, "watchdog", '0, '0);
         report();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) cyc(1, 3'b000, 0, 1, "rst");
      @(negedge clk);
      #5;
      // R1: valid low after reset
      check(word_valid == 1'b0, "R1 reset valid", 64'(word_valid), '0);

      // R2: slot-to-bit mapping, group 0
      run_n(8, 0, "R2 mapping");
      idle(3);

      // R3 + R4: all 16 groups back to back, one word every 8 cycles
      rise_log.delete();
      for (int g = 0; g < 16; g++) run_n(8, g, "R3 group");
      idle(3);
      check(rise_log.size() == 16, "R4 word count", 64'(rise_log.size()), 64'd16);
      for (int i = 1; i < rise_log.size(); i++)
         check(rise_log[i] - rise_log[i-1] == 8, "R4 spacing",
               64'(rise_log[i] - rise_log[i-1]), 64'd8);

      // R8: unselected sources toggle randomly; word must follow group 11 only
      run_n(8, 11, "R8 unselected");
      run_n(8, 15, "R8 unselected");
      idle(3);

      // R5: one control low at a time, no words
      rise_log.delete();
      for (int i = 0; i < 10; i++) cyc(0, 3'b110, 3, 1, "R5");
      for (int i = 0; i < 10; i++) cyc(0, 3'b101, 3, 1, "R5");
      for (int i = 0; i < 10; i++) cyc(0, 3'b011, 3, 1, "R5");
      idle(2);
      check(rise_log.size() == 0, "R5 gated", 64'(rise_log.size()), '0);
      // R5: drop mid-word discards the partial word
      run_n(4, 6, "R5 restart");
      cyc(0, 3'b100, 6, 1, "R5 restart");
      run_n(8, 6, "R5 restart");
      idle(3);

      // R6: group change mid-word, and on the last slot
      run_n(3, 2, "R6 change");
      run_n(8, 9, "R6 change");
      run_n(7, 1, "R6 late change");
      run_n(8, 4, "R6 late change");
      idle(3);

      // R7: backpressure holds the word and pauses sampling
      for (int i = 0; i < 8; i++) cyc(0, 3'b111, 13, 0, "R7 stall");
      for (int i = 0; i < 10; i++) cyc(0, 3'b111, 13, 0, "R7 stall");
      run_n(8, 13, "R7 resume");
      idle(3);

      // R1: reset in the middle of a word
      run_n(5, 7, "R1 midword");
      cyc(1, 3'b111, 7, 1, "R1 midword");
      run_n(8, 7, "R1 midword");
      idle(4);

      check(sb_q.size() == 0, "R4 all words delivered", 64'(sb_q.size()), '0);
      done = 1;
      report();
      $finish;
   end

endmodule